// File: doc/BRIEF.md
# Multi-Channel Event Timer

A word-addressed timer unit holding a set of identical up-counting channels plus one global clock-request register. Each channel sits in its own 64-byte address window. Software stops it, restarts it or clears it by writing to one of three command registers, and the value written does not matter. Through the other registers of the window it picks continuous or one-shot operation, sets the terminal count, reads the running count and a packed status word, and enables and acknowledges the channel's interrupt line.

A channel that is enabled counts up by one on every clock. When its count equals the terminal count, it sets its pending flag and clears the counter. In continuous mode it keeps running. In one-shot mode it stops. With the terminal count left at all ones, the channel serves as a free-running time base. Writes take effect on the clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `event_timer_unit`

## Requirements
- R1: Channel n occupies byte addresses n*0x40 to n*0x40+0x3F. Inside a window the registers are: 0x00 clear, 0x04 start, 0x08 stop, 0x0C mode, 0x10 status, 0x14 count, 0x18 terminal count, 0x1C interrupt enable, 0x20 acknowledge. The clock-request register is at 0x100. The command registers (0x00, 0x04, 0x08) and the acknowledge register read as zero. Unaligned or unlisted addresses read as zero, and writes to them change nothing.
- R2: A write to start, stop or clear acts on the next clock edge, whatever the data.
- R3: A clear write sets the count to zero and leaves the channel stopped and idle. Terminal count, mode, interrupt enable and pending are kept.
- R4: Mode register bit 0 selects the mode: 0 is continuous, 1 is one-shot. The register reads back that bit alone.
- R5: The status word holds the state code in bits [3:0] (1 = idle/stopped, 2 = active/running), the running flag in bit 4, one-shot mode in bit 5, interrupt enable in bit 6 and pending in bit 7. Bits 31:8 read as zero.
- R6: After the start write edge, a running channel counts up from its held value once per clock. When the count equals the terminal count T on an edge, pending sets and the count returns to zero. Starting from zero, pending is therefore first seen T+1 cycles after the start edge. In continuous mode the channel keeps running.
- R7: In one-shot mode the edge that matches also stops the channel. It reads idle, with the running flag clear and the count at zero.
- R8: A stopped channel holds its count and never sets pending, even when the terminal count is rewritten to equal the held count.
- R9: Interrupt enable bit 0 gates the line: irq[n] is high exactly when channel n is pending and enabled.
- R10: A write to the acknowledge register with data bit 7 set clears pending. With bit 7 clear it has no effect. A match on the same edge as an acknowledge wins, and pending stays set.
- R11: After reset every terminal count is 0xFFFFFFFF and every other register is zero. A channel started in that state runs free without setting pending.
- R12: Bit 0 of the register at 0x100 drives clk_req and reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| addr | input | ADDR_W (9) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |
| clk_req | output | 1 | Clock-request enable bit |

## Verification
The main function is swept on every channel, in both modes, over terminal counts 0 to 4. The count and the pending flag are sampled on every cycle from the start edge to the first match, which pins the T+1 timing and shows how continuous and one-shot differ after the match. Directed patterns then cover the following: a held count under stop, a terminal count rewritten to equal the held count, a clear issued mid-run, start and stop with arbitrary data, an acknowledge that coincides with a match, an acknowledge without bit 7, interrupt gating, free running from the reset terminal count, and reads and writes of unmapped and unaligned addresses. Each of these tells a correct priority or decode apart from a plausible wrong one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int DATA_W   = 32;
   localparam int WIN_BITS = 6;
   localparam int ACK_BIT  = 7;

   localparam logic [WIN_BITS-1:0] OFS_CLR  = 6'h00;
   localparam logic [WIN_BITS-1:0] OFS_GO   = 6'h04;
   localparam logic [WIN_BITS-1:0] OFS_HALT = 6'h08;
   localparam logic [WIN_BITS-1:0] OFS_MODE = 6'h0C;
   localparam logic [WIN_BITS-1:0] OFS_STAT = 6'h10;
   localparam logic [WIN_BITS-1:0] OFS_CNT  = 6'h14;
   localparam logic [WIN_BITS-1:0] OFS_TERM = 6'h18;
   localparam logic [WIN_BITS-1:0] OFS_IEN  = 6'h1C;
   localparam logic [WIN_BITS-1:0] OFS_ACK  = 6'h20;

   typedef enum logic [3:0] {
      RS_IDLE   = 4'd1,
      RS_ACTIVE = 4'd2
   } run_state_e;

   // packed: pend is bit 7, state occupies [3:0]
   typedef struct packed {
      logic       pend;
      logic       ien;
      logic       oneshot;
      logic       run;
      run_state_e state;
   } chan_status_t;

   typedef struct packed {
      logic clr;
      logic go;
      logic halt;
      logic mode_wr;
      logic term_wr;
      logic ien_wr;
      logic ack_wr;
   } chan_cmd_t;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
   parameter int NUM_CH  = 4,
   parameter int ADDR_W  = 9,
   parameter int GLB_OFS = 256,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int WIN_W  = ADDR_W - tmr_pkg::WIN_BITS
) (
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   addr,
   output tmr_pkg::chan_cmd_t [NUM_CH-1:0]     cmd,
   output logic                                glb_wr,
   output logic                                glb_hit,
   output logic                                ch_hit,
   output logic [CH_W-1:0]                     ch_idx,
   output logic [tmr_pkg::WIN_BITS-1:0]        ofs
);
   import tmr_pkg::*;

   logic [WIN_W-1:0] win;
   chan_cmd_t        kind;

   assign win     = addr[ADDR_W-1:WIN_BITS];
   assign ofs     = addr[WIN_BITS-1:0];
   assign ch_idx  = win[CH_W-1:0];
   assign ch_hit  = (int'(win) < NUM_CH);
   assign glb_hit = (addr == ADDR_W'(GLB_OFS));
   assign glb_wr  = wr_en && glb_hit;

   always_comb begin
      kind = '0;
      case (ofs)
         OFS_CLR:  kind.clr     = 1'b1;
         OFS_GO:   kind.go      = 1'b1;
         OFS_HALT: kind.halt    = 1'b1;
         OFS_MODE: kind.mode_wr = 1'b1;
         OFS_TERM: kind.term_wr = 1'b1;
         OFS_IEN:  kind.ien_wr  = 1'b1;
         OFS_ACK:  kind.ack_wr  = 1'b1;
         default:  kind         = '0;
      endcase
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign cmd[i] = (wr_en && ch_hit && (ch_idx == CH_W'(i))) ? kind : '0;
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int CNT_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  tmr_pkg::chan_cmd_t           cmd,
   input  logic [tmr_pkg::DATA_W-1:0]   wdata,
   output logic [CNT_W-1:0]             cnt_o,
   output logic [CNT_W-1:0]             term_o,
   output logic                         run_o,
   output logic                         oneshot_o,
   output logic                         ien_o,
   output logic                         pend_o,
   output tmr_pkg::chan_status_t        status_o,
   output logic                         irq_o
);
   import tmr_pkg::*;

   logic [CNT_W-1:0] cnt_q, term_q;
   logic             run_q, oneshot_q, ien_q, pend_q;
   logic             hit;

   assign hit = run_q && (cnt_q == term_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         term_q    <= '1;
         run_q     <= 1'b0;
         oneshot_q <= 1'b0;
         ien_q     <= 1'b0;
         pend_q    <= 1'b0;
      end else begin
         if (cmd.mode_wr) oneshot_q <= wdata[0];
         if (cmd.term_wr) term_q    <= wdata[CNT_W-1:0];
         if (cmd.ien_wr)  ien_q     <= wdata[0];

         if (hit)
            pend_q <= 1'b1;
         else if (cmd.ack_wr && wdata[ACK_BIT])
            pend_q <= 1'b0;

         if (cmd.clr) begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end else if (cmd.halt) begin
            run_q <= 1'b0;
         end else begin
            if (hit) begin
               cnt_q <= '0;
               if (oneshot_q) run_q <= 1'b0;
            end else if (run_q) begin
               cnt_q <= cnt_q + 1'b1;
            end
            if (cmd.go) run_q <= 1'b1;
         end
      end
   end

   always_comb begin
      status_o.pend    = pend_q;
      status_o.ien     = ien_q;
      status_o.oneshot = oneshot_q;
      status_o.run     = run_q;
      status_o.state   = run_q ? RS_ACTIVE : RS_IDLE;
   end

   assign cnt_o     = cnt_q;
   assign term_o    = term_q;
   assign run_o     = run_q;
   assign oneshot_o = oneshot_q;
   assign ien_o     = ien_q;
   assign pend_o    = pend_q;
   assign irq_o     = pend_q && ien_q;

endmodule

// File: rtl/event_timer_unit.sv
module event_timer_unit #(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 9,
   parameter int GLB_OFS = 256
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [tmr_pkg::DATA_W-1:0]  wdata,
   output logic [tmr_pkg::DATA_W-1:0]  rdata,
   output logic [NUM_CH-1:0]           irq,
   output logic                        clk_req
);
   import tmr_pkg::*;

   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int WIN_W = ADDR_W - WIN_BITS;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and the data width");
   end
   if (NUM_CH < 1 || NUM_CH * (1 << WIN_BITS) > GLB_OFS) begin : g_bad_num_ch
      $error("channel windows must end at or below GLB_OFS");
   end
   if (GLB_OFS >= (1 << ADDR_W) || (GLB_OFS % 4) != 0) begin : g_bad_glb
      $error("GLB_OFS must be word aligned and inside the address space");
   end
   if (CH_W > WIN_W) begin : g_bad_addr_w
      $error("ADDR_W too small for NUM_CH");
   end

   chan_cmd_t [NUM_CH-1:0] cmd;
   logic                   glb_wr, glb_hit, ch_hit;
   logic [CH_W-1:0]        ch_idx;
   logic [WIN_BITS-1:0]    ofs;

   logic [CNT_W-1:0]        cnt_a  [NUM_CH];
   logic [CNT_W-1:0]        term_a [NUM_CH];
   chan_status_t            stat_a [NUM_CH];
   logic [NUM_CH-1:0]       run_v, mode_v, ien_v, pend_v;
   logic [NUM_CH-1:0]       clrc_v, goc_v, haltc_v, ackc_v;
   logic [NUM_CH*CNT_W-1:0] cnt_flat, term_flat;
   logic                    clk_req_q;

   tmr_regdec #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .GLB_OFS(GLB_OFS)
   ) u_dec (
      .wr_en  (wr_en),
      .addr   (addr),
      .cmd    (cmd),
      .glb_wr (glb_wr),
      .glb_hit(glb_hit),
      .ch_hit (ch_hit),
      .ch_idx (ch_idx),
      .ofs    (ofs)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd      (cmd[i]),
         .wdata    (wdata),
         .cnt_o    (cnt_a[i]),
         .term_o   (term_a[i]),
         .run_o    (run_v[i]),
         .oneshot_o(mode_v[i]),
         .ien_o    (ien_v[i]),
         .pend_o   (pend_v[i]),
         .status_o (stat_a[i]),
         .irq_o    (irq[i])
      );
      assign cnt_flat[i*CNT_W +: CNT_W]  = cnt_a[i];
      assign term_flat[i*CNT_W +: CNT_W] = term_a[i];
      assign clrc_v[i]  = cmd[i].clr;
      assign goc_v[i]   = cmd[i].go;
      assign haltc_v[i] = cmd[i].halt;
      assign ackc_v[i]  = cmd[i].ack_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      clk_req_q <= 1'b0;
      else if (glb_wr) clk_req_q <= wdata[0];
   end
   assign clk_req = clk_req_q;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (glb_hit) begin
            rdata = DATA_W'(clk_req_q);
         end else if (ch_hit) begin
            case (ofs)
               OFS_MODE: rdata = DATA_W'(mode_v[ch_idx]);
               OFS_STAT: rdata = DATA_W'(stat_a[ch_idx]);
               OFS_CNT:  rdata = DATA_W'(cnt_a[ch_idx]);
               OFS_TERM: rdata = DATA_W'(term_a[ch_idx]);
               OFS_IEN:  rdata = DATA_W'(ien_v[ch_idx]);
               default:  rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 9,
   parameter int GLB_OFS = 256
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rd_en,
   input logic [ADDR_W-1:0]           addr,
   input logic [31:0]                 rdata,
   input logic [NUM_CH-1:0]           irq,
   input logic [NUM_CH-1:0]           run_v,
   input logic [NUM_CH-1:0]           mode_v,
   input logic [NUM_CH-1:0]           ien_v,
   input logic [NUM_CH-1:0]           pend_v,
   input logic [NUM_CH-1:0]           clrc_v,
   input logic [NUM_CH-1:0]           goc_v,
   input logic [NUM_CH-1:0]           haltc_v,
   input logic [NUM_CH-1:0]           ackc_v,
   input logic                        wbit7,
   input logic [NUM_CH*CNT_W-1:0]     cnt_flat,
   input logic [NUM_CH*CNT_W-1:0]     term_flat
);
   logic mapped;
   assign mapped = ((int'(addr) >> 6) < NUM_CH && addr[5:0] <= 6'h20 && addr[1:0] == 2'b00)
                   || (int'(addr) == GLB_OFS);

   // R1
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |-> (rdata == 32'd0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      // R9
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> (ien_v[i] && pend_v[i]));

      // R8
      stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_v[i] && !clrc_v[i]) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

      // R8
      stopped_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_v[i] && !pend_v[i]) |=> !pend_v[i]);

      // R7
      oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[i] && mode_v[i] && cnt_flat[i*CNT_W +: CNT_W] == term_flat[i*CNT_W +: CNT_W]
          && !goc_v[i] && !haltc_v[i] && !clrc_v[i])
         |=> (!run_v[i] && pend_v[i] && cnt_flat[i*CNT_W +: CNT_W] == '0));

      // R10
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ackc_v[i] && wbit7 && !run_v[i]) |=> !pend_v[i]);
   end

endmodule

bind event_timer_unit tmr_unit_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W),
   .GLB_OFS(GLB_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .addr     (addr),
   .rdata    (rdata),
   .irq      (irq),
   .run_v    (run_v),
   .mode_v   (mode_v),
   .ien_v    (ien_v),
   .pend_v   (pend_v),
   .clrc_v   (clrc_v),
   .goc_v    (goc_v),
   .haltc_v  (haltc_v),
   .ackc_v   (ackc_v),
   .wbit7    (wdata[7]),
   .cnt_flat (cnt_flat),
   .term_flat(term_flat)
);

// File: tb/event_timer_unit_tb.sv
`timescale 1ns/1ps
module event_timer_unit_tb;

   localparam logic [8:0] O_CLR = 9'h00, O_GO = 9'h04, O_HALT = 9'h08, O_MODE = 9'h0C,
                          O_STAT = 9'h10, O_CNT = 9'h14, O_TERM = 9'h18, O_IEN = 9'h1C,
                          O_ACK = 9'h20, O_GLB = 9'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;
   logic        clk_req;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   event_timer_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .clk_req(clk_req)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // caller stands just after a falling edge; consumes exactly one clock
   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] v);
      rd_en = 1'b1; addr = a;
      #0.1;
      v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [8:0]  b;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R11 reset state
      for (int c = 0; c < 4; c++) begin
         b = 9'(c * 64);
         rd(b + O_TERM, v); chk("R11 reset term", v, 32'hFFFF_FFFF);
         rd(b + O_STAT, v); chk("R11/R5 reset status idle", v, 32'h01);
         rd(b + O_CNT, v);  chk("R11 reset count", v, 0);
         rd(b + O_MODE, v); chk("R11 reset mode", v, 0);
         cyc(1);
         rd(b + O_IEN, v);  chk("R11 reset ien", v, 0);
         cyc(1);
      end
      chk("R11 reset irq", {28'd0, irq}, 0);
      chk("R11 reset clk_req", {31'd0, clk_req}, 0);

      // R3 clear mid-run keeps terminal count
      b = 9'd128;
      wr(b + O_TERM, 100); wr(b + O_GO, 0); cyc(7);
      rd(b + O_CNT, v); chk("R6 count after 7 cycles", v, 7);
      wr(b + O_CLR, 32'h5);
      rd(b + O_CNT, v);  chk("R3 clear zeroes count", v, 0);
      rd(b + O_STAT, v); chk("R3 clear leaves idle", v, 32'h01);
      rd(b + O_TERM, v); chk("R3 clear keeps term", v, 100);
      cyc(5);
      rd(b + O_CNT, v);  chk("R8 cleared channel holds", v, 0);

      // R2 commands with arbitrary data, R8 stopped hold
      b = 9'd192;
      wr(b + O_TERM, 50); wr(b + O_GO, 32'hDEAD_BEEF); cyc(3);
      rd(b + O_CNT, v);  chk("R2 start with any data", v, 3);
      wr(b + O_HALT, 32'hFFFF_FFFF); cyc(10);
      rd(b + O_CNT, v);  chk("R2/R8 stop holds count", v, 3);
      wr(b + O_TERM, 3); cyc(5);
      rd(b + O_STAT, v); chk("R8 no event while stopped", v, 32'h01);
      wr(b + O_TERM, 20); wr(b + O_GO, 0); cyc(17);
      rd(b + O_CNT, v);  chk("R6 resume from held count", v, 20);
      rd(b + O_STAT, v); chk("R5 running status", v, 32'h12);
      cyc(1);
      rd(b + O_STAT, v); chk("R6 pending on match", v, 32'h92);
      rd(b + O_CNT, v);  chk("R6 count wraps to zero", v, 0);
      chk("R9 irq gated off", {28'd0, irq}, 0);
      wr(b + O_IEN, 1);
      chk("R9 irq when enabled", {28'd0, irq}, 32'h8);
      wr(b + O_HALT, 0);
      wr(b + O_ACK, 32'h7F);
      rd(b + O_STAT, v); chk("R10 ack without bit7 ignored", v, 32'hC1);
      wr(b + O_ACK, 32'h80);
      rd(b + O_STAT, v); chk("R10 ack clears pending", v, 32'h41);
      chk("R9 irq drops after ack", {28'd0, irq}, 0);
      wr(b + O_CLR, 0);

      // R10 match beats ack on the same edge
      b = 9'd0;
      wr(b + O_TERM, 0); wr(b + O_GO, 0); cyc(2);
      wr(b + O_ACK, 32'h80);
      rd(b + O_STAT, v); chk("R10 match wins over ack", v, 32'h92);
      wr(b + O_HALT, 0); wr(b + O_ACK, 32'h80);
      rd(b + O_STAT, v); chk("R10 ack after stop", v, 32'h01);

      // R1 unmapped accesses
      wr(9'h030, 32'hFFFF_FFFF);
      wr(9'h019, 32'h1234);
      rd(9'h018, v); chk("R1 unaligned write ignored", v, 0);
      rd(9'h000, v); chk("R1 command reg reads zero", v, 0);
      cyc(1);
      wr(9'h104, 1);
      chk("R1 write near global ignored", {31'd0, clk_req}, 0);
      rd(9'h024, v); chk("R1 unlisted offset reads zero", v, 0);
      rd(9'h102, v); chk("R1 unaligned read zero", v, 0);
      rd(9'h1FC, v); chk("R1 top address reads zero", v, 0);
      cyc(1);

      // R12 clock request
      wr(O_GLB, 1);
      chk("R12 clk_req set", {31'd0, clk_req}, 1);
      rd(O_GLB, v); chk("R12 clk_req readback", v, 1);
      wr(O_GLB, 32'hFFFF_FFFE);
      chk("R12 clk_req uses bit0", {31'd0, clk_req}, 0);

      // R4 mode register bit 0 only
      b = 9'd64;
      wr(b + O_MODE, 3);
      rd(b + O_MODE, v); chk("R4 mode readback", v, 1);
      wr(b + O_MODE, 2);
      rd(b + O_MODE, v); chk("R4 mode bit0 only", v, 0);

      // R11 free running from reset terminal count
      wr(b + O_GO, 0); cyc(50);
      rd(b + O_CNT, v);  chk("R11 free-running count", v, 50);
      rd(b + O_STAT, v); chk("R11 free-running no pending", v, 32'h12);
      wr(b + O_CLR, 0);

      // sweep: every channel, both modes, terminal counts 0..4
      for (int c = 0; c < 4; c++) begin
         for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 5; t++) begin
               b = 9'(c * 64);
               wr(b + O_CLR, 0); wr(b + O_TERM, 32'(t)); wr(b + O_MODE, 32'(m));
               wr(b + O_IEN, 1); wr(b + O_ACK, 32'h80); wr(b + O_GO, 0);
               for (int k = 0; k <= t; k++) begin
                  rd(b + O_CNT, v);  chk("R6 sweep count", v, 32'(k));
                  rd(b + O_STAT, v); chk("R6 sweep no early pending", {31'd0, v[7]}, 0);
                  cyc(1);
               end
               rd(b + O_STAT, v);
               if (m == 1) chk("R7 one-shot stops on match", v, 32'hE1);
               else        chk("R6 continuous keeps running", v, 32'hD2);
               rd(b + O_CNT, v); chk("R6/R7 count zero after match", v, 0);
               chk("R9 sweep irq line", {28'd0, irq}, 32'(1 << c));
               wr(b + O_HALT, 0); wr(b + O_ACK, 32'h80);
               rd(b + O_STAT, v); chk("R10 sweep ack clears", {31'd0, v[7]}, 0);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule